// File: doc/BRIEF.md
# Accelerator Control Register Block

This block sits on an AXI4-Lite bus and lets a processor run a small hardware function through a start/finish handshake. Software loads three 8-bit operands, sets a go bit, and then either polls a finish flag or waits for the single interrupt line. For test purposes the function is a small accumulate core: it returns `acc_in + x + y` (modulo 256) a fixed number of cycles after it accepts a run.

Each register bit has its own access rule. Some bits are plain storage. Some are read-only views of the core. The finish flag clears when software reads it, the interrupt flags flip when a 1 is written to them, one valid bit clears itself, and the other clears when the core consumes the operand. A loop mode keeps the core restarting without further writes.

Top module: `accel_ctl_regs`

Register map (byte offsets):
- 0x00 control: bit0 go, bit1 finished, bit2 idle, bit3 accepted, bit7 loop mode.
- 0x04 bit0 master interrupt enable.
- 0x08 interrupt mask: bit0 finish channel, bit1 accept channel.
- 0x0C interrupt flags, with the same bit positions as the mask.
- 0x10 bit0 x-valid, bit1 x-taken.
- 0x14 x, 0x18 bit0 y-valid, 0x1C y, 0x24 acc_in, 0x2C result.

## Requirements
- R1: After reset the control register reads 0x04, which means idle only. The mask, the flags, the master enable, the operands and the result all read 0, and `irq` is 0.
- R2: Reserved offsets (0x20, 0x28, unaligned or unmapped addresses) read 0. Writes to them have no effect. Writes to read-only bits (control bits 1–3, offset 0x10 bit1, offset 0x2C) change nothing.
- R3: Write address and write data are accepted in either order. `s_bvalid` and `s_rvalid` are held until accepted. Every response code is 0 (OKAY).
- R4: Each run produces a result at 0x2C equal to (acc_in + x + y) mod 256, using the operand values held when the run was accepted.
- R5: Control bit1 (finished) is set when the core finishes a run. A read of offset 0x00 returns the bit and clears it. If a finish occurs in the same cycle as that read, the bit stays set.
- R6: Control bit0 (go) clears in the cycle after the core accepts a run, unless loop mode is on or the same cycle writes the control register.
- R7: A flag bit at 0x0C is set when its event (bit0 finish, bit1 accept) occurs while the matching mask bit is 1. Writing 1 to a flag bit inverts it. If a set and a toggle fall in the same cycle, the bit ends up 1.
- R8: An event whose mask bit is 0 leaves its flag unchanged.
- R9: `irq` is 1 exactly when the master enable is 1 and at least one flag bit is 1.
- R10: x-valid (0x10 bit0) is writable and clears when the core accepts a run. x-taken (bit1) is set at that acceptance and cleared by a write of x-valid = 1.
- R11: y-valid (0x18 bit0) written as 1 reads 1 for exactly one cycle and then clears itself.
- R12: With loop mode (control bit7) set, go stays 1 and the core starts again after each finish. Clearing go stops the core after the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions matter. A core finish can land in the same cycle as the clear-on-read of the control register, and a flag-setting event can land in the same cycle as a toggle write to the flag register. Loop mode makes finishes and accepts recur on their own, so control-register reads and flag writes issued while the core cycles will repeatedly meet those events. In both cases the set must win: no read ever loses a finish, and a toggle never erases an event that arrived with it. This is judged by properties on the flag transitions and by reading back the final state once the core has been stopped.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;
  // byte offsets seen by software
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_MEN   = 'h04;
  localparam int OFF_MASK  = 'h08;
  localparam int OFF_FLAGS = 'h0C;
  localparam int OFF_XCTL  = 'h10;
  localparam int OFF_X     = 'h14;
  localparam int OFF_YCTL  = 'h18;
  localparam int OFF_Y     = 'h1C;
  localparam int OFF_ACC   = 'h24;
  localparam int OFF_RES   = 'h2C;

  localparam logic [1:0] RESP_OK = 2'b00;

  // modular accumulate of the test core
  function automatic logic [7:0] acc_sum(input logic [7:0] c, input logic [7:0] a,
                                         input logic [7:0] b);
    return c + a + b;
  endfunction
endpackage

// File: rtl/accel_ctl_core.sv
module accel_ctl_core #(
  parameter int ARG_W = 8,
  parameter int LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [ARG_W-1:0] x_in,
  input  logic [ARG_W-1:0] y_in,
  input  logic [ARG_W-1:0] acc_in,
  output logic             quiet,
  output logic             start,
  output logic             done,
  output logic [ARG_W-1:0] result
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [ARG_W-1:0] x_l, y_l, c_l;

  assign quiet = !busy;
  assign start = go && !busy;
  assign done  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      x_l    <= '0;
      y_l    <= '0;
      c_l    <= '0;
      result <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(LAT - 1);
      x_l  <= x_in;
      y_l  <= y_in;
      c_l  <= acc_in;
    end else if (done) begin
      busy   <= 1'b0;
      result <= ARG_W'(accel_ctl_pkg::acc_sum(8'(c_l), 8'(x_l), 8'(y_l)));
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/accel_ctl_irq.sv
module accel_ctl_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] events,
  input  logic [NCH-1:0] mask,
  input  logic           tog_we,
  input  logic [NCH-1:0] tog_bits,
  input  logic           master_en,
  output logic [NCH-1:0] flags,
  output logic           irq
);
  logic [NCH-1:0] flags_n;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      flags_n[i] = flags[i] ^ (tog_we & tog_bits[i]);
      if (events[i] && mask[i]) flags_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_n;
  end

  assign irq = master_en && (|flags);
endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
  import accel_ctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int ARG_W  = 8,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              irq
);
  // write channel capture
  logic              aw_full, w_full;
  logic [ADDR_W-1:0] aw_q;
  logic [DATA_W-1:0] w_q;
  logic              wr_commit;

  assign s_awready = !aw_full;
  assign s_wready  = !w_full;
  assign wr_commit = aw_full && w_full && !s_bvalid;
  assign s_bresp   = RESP_OK;
  assign s_rresp   = RESP_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full  <= 1'b0;
      w_full   <= 1'b0;
      aw_q     <= '0;
      w_q      <= '0;
      s_bvalid <= 1'b0;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_full <= 1'b1;
        aw_q    <= s_awaddr;
      end
      if (s_wvalid && s_wready) begin
        w_full <= 1'b1;
        w_q    <= s_wdata;
      end
      if (wr_commit) begin
        aw_full  <= 1'b0;
        w_full   <= 1'b0;
        s_bvalid <= 1'b1;
      end else if (s_bvalid && s_bready) begin
        s_bvalid <= 1'b0;
      end
    end
  end

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  // decoded write strobes, named for the checker
  logic wr_ctrl, wr_men, wr_mask, wr_flags, wr_xctl, wr_x, wr_yctl, wr_y, wr_acc;
  assign wr_ctrl  = wr_commit && hit(aw_q, OFF_CTRL);
  assign wr_men   = wr_commit && hit(aw_q, OFF_MEN);
  assign wr_mask  = wr_commit && hit(aw_q, OFF_MASK);
  assign wr_flags = wr_commit && hit(aw_q, OFF_FLAGS);
  assign wr_xctl  = wr_commit && hit(aw_q, OFF_XCTL);
  assign wr_x     = wr_commit && hit(aw_q, OFF_X);
  assign wr_yctl  = wr_commit && hit(aw_q, OFF_YCTL);
  assign wr_y     = wr_commit && hit(aw_q, OFF_Y);
  assign wr_acc   = wr_commit && hit(aw_q, OFF_ACC);

  // core and events
  logic             go_q, loop_q, fin_q, men_q;
  logic [1:0]       mask_q;
  logic             x_vld, x_tkn, y_vld;
  logic [ARG_W-1:0] x_val, y_val, acc_val, res_val;
  logic             core_quiet, core_start, core_done;
  logic [1:0]       flags;

  accel_ctl_core #(.ARG_W(ARG_W), .LAT(LAT)) u_core (
    .clk(clk), .rst_n(rst_n), .go(go_q),
    .x_in(x_val), .y_in(y_val), .acc_in(acc_val),
    .quiet(core_quiet), .start(core_start), .done(core_done), .result(res_val)
  );

  accel_ctl_irq #(.NCH(2)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .events({core_start, core_done}), .mask(mask_q),
    .tog_we(wr_flags), .tog_bits(w_q[1:0]),
    .master_en(men_q), .flags(flags), .irq(irq)
  );

  // read channel
  logic rd_fire, rd_ctrl;
  logic [DATA_W-1:0] rd_word;

  assign s_arready = !s_rvalid;
  assign rd_fire   = s_arvalid && s_arready;
  assign rd_ctrl   = rd_fire && hit(s_araddr, OFF_CTRL);

  always_comb begin
    rd_word = '0;
    if      (hit(s_araddr, OFF_CTRL))  rd_word = DATA_W'({loop_q, 3'b000, core_start, core_quiet, fin_q, go_q});
    else if (hit(s_araddr, OFF_MEN))   rd_word = DATA_W'(men_q);
    else if (hit(s_araddr, OFF_MASK))  rd_word = DATA_W'(mask_q);
    else if (hit(s_araddr, OFF_FLAGS)) rd_word = DATA_W'(flags);
    else if (hit(s_araddr, OFF_XCTL))  rd_word = DATA_W'({x_tkn, x_vld});
    else if (hit(s_araddr, OFF_X))     rd_word = DATA_W'(x_val);
    else if (hit(s_araddr, OFF_YCTL))  rd_word = DATA_W'(y_vld);
    else if (hit(s_araddr, OFF_Y))     rd_word = DATA_W'(y_val);
    else if (hit(s_araddr, OFF_ACC))   rd_word = DATA_W'(acc_val);
    else if (hit(s_araddr, OFF_RES))   rd_word = DATA_W'(res_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (rd_fire) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_word;
    end else if (s_rvalid && s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  // register bank with per-bit access rules
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      loop_q  <= 1'b0;
      fin_q   <= 1'b0;
      men_q   <= 1'b0;
      mask_q  <= '0;
      x_vld   <= 1'b0;
      x_tkn   <= 1'b0;
      y_vld   <= 1'b0;
      x_val   <= '0;
      y_val   <= '0;
      acc_val <= '0;
    end else begin
      if (core_start && !loop_q) go_q <= 1'b0;
      if (wr_ctrl) begin
        go_q   <= w_q[0];
        loop_q <= w_q[7];
      end
      if (core_done)    fin_q <= 1'b1;
      else if (rd_ctrl) fin_q <= 1'b0;
      if (wr_men)  men_q  <= w_q[0];
      if (wr_mask) mask_q <= w_q[1:0];
      if (core_start) begin
        x_vld <= 1'b0;
        x_tkn <= 1'b1;
      end
      if (wr_xctl) begin
        x_vld <= w_q[0];
        if (w_q[0]) x_tkn <= 1'b0;
      end
      y_vld <= wr_yctl && w_q[0];
      if (wr_x)   x_val   <= w_q[ARG_W-1:0];
      if (wr_y)   y_val   <= w_q[ARG_W-1:0];
      if (wr_acc) acc_val <= w_q[ARG_W-1:0];
    end
  end
endmodule

// File: rtl/accel_ctl_chk.sv
module accel_ctl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              go,
  input logic              loop_en,
  input logic              wr_ctrl,
  input logic              fin,
  input logic              y_vld,
  input logic [1:0]        flags,
  input logic [1:0]        mask,
  input logic              wr_flags,
  input logic              bvalid,
  input logic              bready,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        bresp,
  input logic [1:0]        rresp
);
  // R6
  go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !loop_en && !wr_ctrl) |=> !go);
  // R5
  fin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> fin);
  // R11
  y_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |=> !y_vld);
  // R7
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mask[0]) |=> flags[0]);
  // R8
  flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flags && !(done && mask[0])) |=> $stable(flags[0]));
  // R3
  bhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  // R3
  rhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  // R3
  resp_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid || rvalid) |-> (bresp == 2'b00 && rresp == 2'b00));
endmodule

bind accel_ctl_regs accel_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(core_start), .done(core_done),
  .go(go_q), .loop_en(loop_q), .wr_ctrl(wr_ctrl), .fin(fin_q), .y_vld(y_vld),
  .flags(flags), .mask(mask_q), .wr_flags(wr_flags),
  .bvalid(s_bvalid), .bready(s_bready), .rvalid(s_rvalid), .rready(s_rready),
  .rdata(s_rdata), .bresp(s_bresp), .rresp(s_rresp)
);

// File: tb/sim_accel_ctl_regs.sv
`timescale 1ns/1ps
module sim_accel_ctl_regs;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [DW-1:0] wdata = '0;
  logic awready, wready, bvalid, arready, rvalid, irq;
  logic [1:0] bresp, rresp;
  logic [DW-1:0] rdata;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  accel_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // wfirst = 1 presents data before the address
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit wfirst = 0);
    bit aw_done = 0, w_done = 0, ah, wh;
    @(negedge clk);
    awaddr = a; wdata = d;
    wvalid = 1'b1;
    awvalid = !wfirst;
    while (!(aw_done && w_done)) begin
      ah = awvalid && awready;
      wh = wvalid && wready;
      @(posedge clk);
      @(negedge clk);
      if (ah) begin awvalid = 1'b0; aw_done = 1; end
      if (wh) begin wvalid = 1'b0; w_done = 1; end
      if (w_done && !aw_done) awvalid = 1'b1;
    end
    bready = 1'b1;
    while (!bvalid) @(negedge clk);
    check("R3 bresp", 32'(bresp), 0);
    @(posedge clk);
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    // hold off rready one cycle: data must stay put
    d = rdata;
    @(negedge clk);
    check("R3 rvalid held", 32'(rvalid), 1);
    check("R3 rdata stable", rdata, d);
    check("R3 rresp", 32'(rresp), 0);
    rready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic wait_fin(output logic [DW-1:0] c);
    c = '0;
    for (int k = 0; k < 50; k++) begin
      rd(6'h00, c);
      if (c[1]) break;
    end
  endtask

  logic [DW-1:0] v;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(6'h00, v); check("R1 ctrl", v, 32'h04);
    rd(6'h08, v); check("R1 mask", v, 0);
    rd(6'h0C, v); check("R1 flags", v, 0);
    rd(6'h2C, v); check("R1 result", v, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 reserved and read-only
    wr(6'h20, 32'hFF); rd(6'h20, v); check("R2 reserved 0x20", v, 0);
    wr(6'h28, 32'hFF); rd(6'h28, v); check("R2 reserved 0x28", v, 0);
    rd(6'h15, v); check("R2 unaligned", v, 0);
    wr(6'h2C, 32'h77); rd(6'h2C, v); check("R2 result read-only", v, 0);
    wr(6'h00, 32'h0E); rd(6'h00, v); check("R2 ctrl ro bits", v, 32'h04);

    // R3 data-first ordering
    wr(6'h14, 32'h5A, 1); rd(6'h14, v); check("R3 w before aw", v, 32'h5A);

    // R10 x-valid
    wr(6'h10, 32'h3); rd(6'h10, v); check("R10 x-valid set, taken ro", v, 32'h1);
    // R11 y-valid self clear
    wr(6'h18, 32'h1); rd(6'h18, v); check("R11 y-valid cleared", v, 0);

    // R4 sweep
    begin
      logic [7:0] av[4] = '{8'd5, 8'd0, 8'd100, 8'd255};
      logic [7:0] bv[4] = '{8'd10, 8'd0, 8'd200, 8'd255};
      logic [7:0] cv[3] = '{8'd0, 8'd7, 8'd255};
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int k = 0; k < 3; k++) begin
            wr(6'h14, 32'(av[i])); wr(6'h1C, 32'(bv[j])); wr(6'h24, 32'(cv[k]));
            wr(6'h00, 32'h1);
            wait_fin(v);
            check("R5 finished seen", 32'(v[1]), 1);
            check("R6 go cleared", 32'(v[0]), 0);
            rd(6'h2C, v);
            check("R4 result", v, 32'((32'(av[i]) + 32'(bv[j]) + 32'(cv[k])) % 256));
          end
    end
    rd(6'h00, v); check("R5 cleared by read", v, 32'h04);
    rd(6'h10, v); check("R10 x consumed", v, 32'h2);
    wr(6'h10, 32'h1); rd(6'h10, v); check("R10 taken cleared", v, 32'h1);

    // R8 masked events leave flags
    rd(6'h0C, v); check("R8 flags masked", v, 0);
    // R7 finish channel
    wr(6'h08, 32'h1); wr(6'h04, 32'h1);
    wr(6'h00, 32'h1); wait_fin(v);
    rd(6'h0C, v); check("R7 finish flag", v, 32'h1);
    check("R9 irq high", 32'(irq), 1);
    wr(6'h04, 32'h0); check("R9 irq master off", 32'(irq), 0);
    wr(6'h0C, 32'h1); rd(6'h0C, v); check("R7 toggle clears", v, 0);
    wr(6'h0C, 32'h1); rd(6'h0C, v); check("R7 toggle sets", v, 32'h1);
    wr(6'h0C, 32'h1);
    // accept channel only
    wr(6'h08, 32'h2); wr(6'h00, 32'h1); wait_fin(v);
    rd(6'h0C, v); check("R8 accept only", v, 32'h2);
    wr(6'h0C, 32'h2); wr(6'h08, 32'h0);

    // R12 loop mode with collisions against reads and toggles
    wr(6'h14, 32'd5); wr(6'h1C, 32'd10); wr(6'h24, 32'd0);
    wr(6'h08, 32'h1);
    wr(6'h00, 32'h81);
    for (int n = 0; n < 12; n++) begin
      rd(6'h00, v);
      check("R12 go stays", 32'(v[0]), 1);
      wr(6'h0C, 32'h1);
    end
    wr(6'h00, 32'h00);
    repeat (10) @(negedge clk);
    rd(6'h00, v); check("R12 stopped idle", v & 32'h85, 32'h04);
    rd(6'h2C, v); check("R12 result", v, 32'd15);
    wr(6'h08, 32'h0);
    rd(6'h0C, v); wr(6'h0C, v);
    rd(6'h0C, v); check("R7 flags cleared", v, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule